// File: doc/BRIEF.md
# Post-Trigger Bus Trace Capture

This block keeps a rolling record of every monitored line of a target processor, one record per bus cycle. Each record holds the lines' fault-free values, which come from the monitor taps of the injection switches. After being armed it writes into a circular on-chip buffer without stopping. When the fault sequencer signals the injection instant, the block notes the buffer address of that moment. It then keeps recording until the buffer has been rewritten end to end, and freezes.

When the capture is frozen, host software unloads the buffer through a simple indexed read port. Index 0 is always the oldest entry, which is the record of the injection cycle, and the latched trigger address is also available. Optionally, the top lanes of every record are replaced by a small counter that starts at zero on arming. This lets software measure time between records even when bus cycles are irregular.

Top module: `trace_capture`

## Requirements
- R1: During and directly after reset, `done_o` and `rd_valid_o` are 0 and `trig_addr_o` is 0.
- R2: Records are written only between arming and completion, one per clock with `cyc_i` high. A `trig_i` pulse before any arm has no effect, and `done_o` stays 0.
- R3: A `trig_i` pulse while recording before the trigger latches `trig_addr_o` = (number of records written since arm) mod DEPTH.
- R4: After the trigger, `done_o` rises on the clock after the DEPTH-th post-trigger record is written. If `cyc_i` is high in the trigger cycle, that record is the first post-trigger record.
- R5: Once `done_o` is 1, `cyc_i`, `trig_i` and `lines_i` have no effect. The buffer contents and `trig_addr_o` stay unchanged until the next arm.
- R6: A read request (`rd_en_i`) is served only when `done_o` is 1. `rd_valid_o` is 1 on the clock after a served request, and 0 after a request made while not done.
- R7: Read index k returns the k-th oldest record. After completion this is the k-th post-trigger record, with k = 0 being the trigger-cycle record.
- R8: With TS_EN = 1, bits [LANES-1 : LANES-TS_W] of each record hold a timestamp and the lower bits hold `lines_i`. The timestamp is 0 in the first clock after the arm clock, increments every clock, and wraps at 2^TS_W.
- R9: With TS_EN = 0, every bit of a record is the corresponding bit of `lines_i`.
- R10: `arm_i` always restarts the capture: `done_o` is 0 on the following clock and the write position returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start a new capture (clears position and timestamp) |
| cyc_i | input | 1 | Bus-cycle strobe; one record per asserted clock |
| trig_i | input | 1 | Injection instant from the fault sequencer |
| lines_i | input | LANES | Fault-free values of the monitored lines |
| rd_en_i | input | 1 | Host read request |
| rd_idx_i | input | $clog2(DEPTH) | Read index, 0 = oldest entry |
| done_o | output | 1 | Capture complete, buffer frozen |
| trig_addr_o | output | $clog2(DEPTH) | Buffer address of the injection cycle |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | LANES | Read data |

## Verification
The number of pre-trigger records is swept from 0 to past twice the depth. This makes the latched trigger address wrap through every value and tells a wrong modulo apart from a correct one. The trigger alternates between cycles with and without a bus strobe, and idle gaps are placed between records. Together these separate a write counted per clock from one counted per bus cycle, and an off-by-one in the completion count. One long pre-trigger run pushes the timestamp through its 256 wrap. A second instance without timestamps shows the lanes pass through unchanged. Strobes and triggers sent after completion, and reads requested before it, show that a frozen or unfinished capture is left alone.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int DEF_LANES = 96;
    localparam int DEF_DEPTH = 4096;
    localparam int DEF_TS_W  = 8;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PRE  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    function automatic logic cap_recording(input cap_state_e st);
        return (st == CAP_PRE) || (st == CAP_POST);
    endfunction

endpackage

// File: rtl/trace_stamp.sv
module trace_stamp
    import trace_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int TS_W  = DEF_TS_W,
    parameter bit TS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [LANES-1:0] lines_i,
    output logic [LANES-1:0] rec_o
);

    generate
        if (TS_EN) begin : g_stamp
            logic [TS_W-1:0] ts_q;

            always_ff @(posedge clk) begin
                if (rst || clr) ts_q <= '0;
                else            ts_q <= ts_q + 1'b1;
            end

            always_comb rec_o = {ts_q, lines_i[LANES-TS_W-1:0]};
        end else begin : g_plain
            always_comb rec_o = lines_i;
        end
    endgenerate

endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
    parameter int W  = 96,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int N = 1 << AW;

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          cyc,
    input  logic          trig,
    output logic          we,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] trig_addr,
    output logic          done
);

    cap_state_e    st_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] post_q;
    logic [AW-1:0] trig_q;

    always_comb we = cyc && !arm && cap_recording(st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CAP_IDLE;
            wptr_q <= '0;
            post_q <= '0;
            trig_q <= '0;
        end else if (arm) begin
            st_q   <= CAP_PRE;
            wptr_q <= '0;
            post_q <= '0;
            trig_q <= '0;
        end else begin
            if (we) wptr_q <= wptr_q + 1'b1;
            case (st_q)
                CAP_PRE: begin
                    if (trig) begin
                        st_q   <= CAP_POST;
                        trig_q <= wptr_q;
                        post_q <= cyc ? AW'(1) : '0;
                    end
                end
                CAP_POST: begin
                    if (cyc) begin
                        post_q <= post_q + 1'b1;
                        if (post_q == '1) st_q <= CAP_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wptr      = wptr_q;
        trig_addr = trig_q;
        done      = (st_q == CAP_DONE);
    end

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trace_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int DEPTH = DEF_DEPTH,
    parameter int TS_W  = DEF_TS_W,
    parameter bit TS_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arm_i,
    input  logic                     cyc_i,
    input  logic                     trig_i,
    input  logic [LANES-1:0]         lines_i,
    input  logic                     rd_en_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic                     done_o,
    output logic [$clog2(DEPTH)-1:0] trig_addr_o,
    output logic                     rd_valid_o,
    output logic [LANES-1:0]         rd_data_o
);

    localparam int AW = $clog2(DEPTH);

    logic          we;
    logic [AW-1:0] wptr;
    logic [AW-1:0] raddr;
    logic          rd_fire;
    logic          rd_valid_q;
    logic [LANES-1:0] rec;

    trace_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm_i),
        .cyc       (cyc_i),
        .trig      (trig_i),
        .we        (we),
        .wptr      (wptr),
        .trig_addr (trig_addr_o),
        .done      (done_o)
    );

    trace_stamp #(.LANES(LANES), .TS_W(TS_W), .TS_EN(TS_EN)) u_stamp (
        .clk     (clk),
        .rst     (rst),
        .clr     (arm_i),
        .lines_i (lines_i),
        .rec_o   (rec)
    );

    // Oldest entry sits at the next write position once the buffer is full.
    always_comb begin
        rd_fire = rd_en_i && done_o;
        raddr   = wptr + rd_idx_i;
    end

    trace_ram #(.W(LANES), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (wptr),
        .wdata (rec),
        .re    (rd_fire),
        .raddr (raddr),
        .rdata (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid_q <= 1'b0;
        else     rd_valid_q <= rd_fire;
    end

    always_comb rd_valid_o = rd_valid_q;

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
    parameter int TA_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            arm_i,
    input logic            cyc_i,
    input logic            rd_en_i,
    input logic            done_o,
    input logic            rd_valid_o,
    input logic [TA_W-1:0] trig_addr_o
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_o && !rd_valid_o && trig_addr_o == '0));

    a_r4_done_on_bus_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(cyc_i));

    a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> (done_o && $stable(trig_addr_o)));

    a_r6_read_only_when_done: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> ($past(done_o) && $past(rd_en_i)));

    a_r10_arm_restarts: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !done_o);

endmodule

bind trace_capture trace_capture_chk #(.TA_W($clog2(DEPTH))) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .cyc_i       (cyc_i),
    .rd_en_i     (rd_en_i),
    .done_o      (done_o),
    .rd_valid_o  (rd_valid_o),
    .trig_addr_o (trig_addr_o)
);

// File: tb/tb_trace_capture.sv
module tb_trace_capture;

    localparam int LANES = 16;
    localparam int DEPTH = 16;
    localparam int TS_W  = 8;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm_i = 1'b0, cyc_i = 1'b0, trig_i = 1'b0, rd_en_i = 1'b0;
    logic [LANES-1:0] lines_i = '0;
    logic [AW-1:0]    rd_idx_i = '0;
    logic             done_a, done_b, rv_a, rv_b;
    logic [AW-1:0]    ta_a, ta_b;
    logic [LANES-1:0] rd_a, rd_b;

    int checks = 0, fails = 0;
    int tick = 0, a0 = 0, seq = 0;
    logic [LANES-1:0] exp_lines [DEPTH];
    logic [TS_W-1:0]  exp_ts    [DEPTH];

    always #4 clk = ~clk;

    trace_capture #(.LANES(LANES), .DEPTH(DEPTH), .TS_W(TS_W), .TS_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .cyc_i(cyc_i), .trig_i(trig_i),
        .lines_i(lines_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .done_o(done_a), .trig_addr_o(ta_a), .rd_valid_o(rv_a), .rd_data_o(rd_a));

    trace_capture #(.LANES(LANES), .DEPTH(DEPTH), .TS_W(TS_W), .TS_EN(1'b0)) dut_nt (
        .clk(clk), .rst(rst), .arm_i(arm_i), .cyc_i(cyc_i), .trig_i(trig_i),
        .lines_i(lines_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .done_o(done_b), .trig_addr_o(ta_b), .rd_valid_o(rv_b), .rd_data_o(rd_b));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        tick++;
    endtask

    task automatic idle_in();
        arm_i = 0; cyc_i = 0; trig_i = 0; rd_en_i = 0;
    endtask

    function automatic logic [LANES-1:0] pat(input int s);
        return LANES'(s * 40503 + 4660);
    endfunction

    // Drive one clock; returns the record's timestamp when cyc is set.
    task automatic drive(input bit c, input bit t, output logic [LANES-1:0] l,
                         output logic [TS_W-1:0] ts);
        idle_in();
        cyc_i = c; trig_i = t;
        l = pat(seq); seq++;
        lines_i = l;
        ts = TS_W'(tick - a0);
        step();
    endtask

    task automatic run_case(input int pre, input bit trig_cyc, input int gap);
        logic [LANES-1:0] l;
        logic [TS_W-1:0]  ts;
        int npost = 0;
        bit was_done = done_a;
        idle_in(); arm_i = 1; step(); a0 = tick;
        idle_in();
        if (was_done) chk(!done_a && !done_b, "R10", "done after re-arm", done_a, 0);
        for (int i = 0; i < pre; i++) begin
            drive(1, 0, l, ts);
            if (i % gap == 0) drive(0, 0, l, ts);
        end
        chk(!done_a, "R4", "done before trigger", done_a, 0);
        drive(trig_cyc, 1, l, ts);
        if (trig_cyc) begin exp_lines[0] = l; exp_ts[0] = ts; npost = 1; end
        while (npost < DEPTH) begin
            if (npost % 2 == 1) drive(0, 0, l, ts);
            if (npost == DEPTH - 1)
                chk(!done_a && !done_b, "R4", "done before last record", done_a, 0);
            drive(1, 0, l, ts);
            exp_lines[npost] = l; exp_ts[npost] = ts; npost++;
        end
        chk(done_a && done_b, "R4", "done after last record", done_a, 1);
        chk(ta_a == AW'(pre) && ta_b == AW'(pre), "R3", "trigger address",
            ta_a, pre % DEPTH);
        // Traffic after completion must leave everything alone.
        for (int i = 0; i < 3; i++) drive(1, 1, l, ts);
        chk(done_a && ta_a == AW'(pre), "R5", "state after late traffic", ta_a, pre % DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            idle_in(); rd_en_i = 1; rd_idx_i = AW'(k);
            step();
            chk(rv_a && rv_b, "R6", "read valid", rv_a, 1);
            chk(rd_a == {exp_ts[k], exp_lines[k][LANES-TS_W-1:0]}, "R7 R8",
                $sformatf("stamped entry %0d", k), rd_a,
                {exp_ts[k], exp_lines[k][LANES-TS_W-1:0]});
            chk(rd_b == exp_lines[k], "R9 R5", $sformatf("plain entry %0d", k),
                rd_b, exp_lines[k]);
        end
        idle_in(); step();
        chk(!rv_a, "R6", "valid drops without request", rv_a, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle_in();
        repeat (3) step();
        rst = 0;
        step();
        chk(!done_a && !rv_a && ta_a == '0, "R1", "reset outputs", {done_a, rv_a}, 0);
        // Trigger and strobes with no arm do nothing.
        cyc_i = 1; trig_i = 1; lines_i = '1;
        repeat (DEPTH + 4) step();
        idle_in();
        chk(!done_a && !done_b, "R2", "trigger before arm ignored", done_a, 0);
        rd_en_i = 1; step();
        idle_in(); step();
        chk(!rv_a && !rv_b, "R6", "read refused while not done", rv_a, 0);
        for (int p = 0; p < 2 * DEPTH + 3; p++) run_case(p, p[0], (p % 3) + 1);
        run_case(300, 1'b1, 1000);
        run_case(5, 1'b0, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule